// File: doc/BRIEF.md
# Mode-Switched Redundant Scan Register

This block is a short scan register, three stages by default, whose stored bits are hidden from anyone who shifts it while it is running in the field. Every stage is a mux-D flip-flop. The stage either loads capture data from the surrounding logic or takes shift data from the stage before it. Stage 0 receives the serial scan input, and the last stage drives the serial scan output.

A single mode input chooses how the bits are kept. In test mode the flip-flops hold the plain shift-register value, so a tester sees the expected state sequence. In system mode the stored word is re-encoded through a state-dependent inversion mask. Bit 0 is always stored inverted. Bit 1 is also stored inverted whenever the logical value of a selector stage is 1. This gives a permutation of the state set, and its transition graph is isomorphic to the plain register's. XOR correction on the stage inputs and on the scan output keeps the serial behaviour identical to a plain shift register in both modes. A change of mode re-encodes the held value at the next clock edge, so no logical data is lost. The raw flip-flop contents are brought out for verification.

Top module: `redscan_reg`

## Requirements
- R1: Reset is synchronous and active high. After a clock edge with `rst`=1, the logical value is all zeros. `raw_state` then reads 0 if `sys_mode` was 0 at that edge, and 3'b001 if it was 1 (default parameters).
- R2: `sys_mode`=0 selects test mode and `sys_mode`=1 selects system mode. The encoding used after an edge is the one selected at that edge.
- R3: In test mode, `raw_state` equals the plain shift-register value after every clock edge.
- R4: In system mode, `raw_state` equals L XOR M, where L is the logical value. M has bit 0 set, has bit 1 equal to L[SEL_BIT] (default SEL_BIT=2), and has all other bits clear.
- R5: With `scan_en`=1, logical stage 0 takes `scan_in` and stage k takes stage k-1. `scan_out` is logical stage STAGES-1 in both modes.
- R6: With `scan_en`=0, every logical stage k loads `cap_data[k]` in both modes, and `scan_out` then shows `cap_data[STAGES-1]`.
- R7: Changing `sys_mode` between edges loses no logical data. The scan-out sequence continues exactly as in a plain register while the mode toggles.
- R8: In system mode, `raw_state` differs from the plain register value for every one of the possible logical values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sys_mode | input | 1 | 0 = test mode, 1 = system mode |
| scan_en | input | 1 | 1 = shift, 0 = capture |
| scan_in | input | 1 | Serial scan input into stage 0 |
| cap_data | input | STAGES | Capture data, one bit per stage |
| scan_out | output | 1 | Serial scan output, logical last stage |
| raw_state | output | STAGES | Raw flip-flop contents |

## Verification
Every result of this block becomes visible one clock edge after the inputs that cause it: the stored word, `scan_out` and `raw_state` all change at that edge, with no further pipeline stage. The bench drives inputs on the falling edge and advances its plain reference register at the rising edge. It then compares `scan_out` and the mode-encoded expected `raw_state` at the following falling edge, which is half a period after the edge that produced them. Mode toggles count as ordinary inputs of that same cycle. The expected encoding uses the mode that was driven before the edge, not the one driven afterwards.

// File: rtl/redscan_reg.sv
module redscan_reg #(
  parameter int STAGES  = 3,
  parameter int SEL_BIT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sys_mode,
  input  logic              scan_en,
  input  logic              scan_in,
  input  logic [STAGES-1:0] cap_data,
  output logic              scan_out,
  output logic [STAGES-1:0] raw_state
);
  localparam int LAST = STAGES - 1;

  // Mask never touches SEL_BIT (>= 2), so it can be decoded from stored bits.
  function automatic logic [STAGES-1:0] mask_of(input logic [STAGES-1:0] v);
    logic [STAGES-1:0] m;
    m    = '0;
    m[0] = 1'b1;
    m[1] = v[SEL_BIT];
    return m;
  endfunction

  logic [STAGES-1:0] phys_q;
  logic              enc_q;
  logic [STAGES-1:0] logic_v;
  logic [STAGES-1:0] stage_d;
  logic [STAGES-1:0] phys_d;

  assign logic_v = phys_q ^ (enc_q ? mask_of(phys_q) : '0);

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign stage_d[k] = rst ? 1'b0 : (scan_en ? scan_in : cap_data[k]);
    end else begin : g_body
      assign stage_d[k] = rst ? 1'b0 : (scan_en ? logic_v[k-1] : cap_data[k]);
    end
  end

  assign phys_d = stage_d ^ (sys_mode ? mask_of(stage_d) : '0);

  always_ff @(posedge clk) begin
    phys_q <= phys_d;
    enc_q  <= sys_mode;
  end

  assign scan_out  = logic_v[LAST];
  assign raw_state = phys_q;
endmodule

// File: rtl/redscan_reg_chk.sv
module redscan_reg_chk #(
  parameter int STAGES = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              sys_mode,
  input logic              scan_en,
  input logic              scan_in,
  input logic [STAGES-1:0] cap_data,
  input logic              scan_out,
  input logic [STAGES-1:0] raw_state
);
  logic armed = 1'b0;
  always_ff @(posedge clk) if (rst) armed <= 1'b1;

  p_reset_zero_r1: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(rst) |-> (scan_out == 1'b0));

  p_test_plain_r3: assert property (@(posedge clk) disable iff (rst || !armed)
    !$past(sys_mode) |-> (scan_out == raw_state[STAGES-1]));

  p_shift_r5: assert property (@(posedge clk) disable iff (rst || !armed)
    (!$past(rst) && !$past(sys_mode) && $past(scan_en) && !sys_mode && scan_en)
      |=> (raw_state[1] == $past(raw_state[0])));

  p_capture_out_r6: assert property (@(posedge clk) disable iff (rst || !armed)
    (!$past(rst) && !$past(scan_en)) |-> (scan_out == $past(cap_data[STAGES-1])));

  p_sys_bit0_inv_r4: assert property (@(posedge clk) disable iff (rst || !armed)
    (!$past(rst) && !$past(scan_en) && $past(sys_mode)) |-> (raw_state[0] == !$past(cap_data[0])));

  p_sys_shift_in_r8: assert property (@(posedge clk) disable iff (rst || !armed)
    (!$past(rst) && $past(scan_en) && $past(sys_mode)) |-> (raw_state[0] == !$past(scan_in)));
endmodule

bind redscan_reg redscan_reg_chk #(.STAGES(STAGES)) u_chk (
  .clk(clk), .rst(rst), .sys_mode(sys_mode), .scan_en(scan_en), .scan_in(scan_in),
  .cap_data(cap_data), .scan_out(scan_out), .raw_state(raw_state)
);

// File: tb/redscan_reg_tb.sv
module redscan_reg_tb;
  localparam int STAGES  = 3;
  localparam int SEL_BIT = 2;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst, sys_mode, scan_en, scan_in;
  logic [STAGES-1:0] cap_data;
  logic scan_out;
  logic [STAGES-1:0] raw_state;

  int checks = 0;
  int errors = 0;
  logic [STAGES-1:0] plain_q;
  logic mode_at_edge;

  always #(CLK_PERIOD/2) clk = ~clk;

  redscan_reg #(.STAGES(STAGES), .SEL_BIT(SEL_BIT)) u_dut (
    .clk(clk), .rst(rst), .sys_mode(sys_mode), .scan_en(scan_en), .scan_in(scan_in),
    .cap_data(cap_data), .scan_out(scan_out), .raw_state(raw_state)
  );

  function automatic logic [STAGES-1:0] exp_raw(input logic [STAGES-1:0] l, input logic m);
    logic [STAGES-1:0] k;
    k = '0;
    if (m) begin
      k[0] = 1'b1;
      k[1] = l[SEL_BIT];
    end
    return l ^ k;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic m, input logic se, input logic si,
                      input logic [STAGES-1:0] cd, input string req);
    logic [STAGES-1:0] er;
    rst = r; sys_mode = m; scan_en = se; scan_in = si; cap_data = cd;
    @(posedge clk);
    if (r) plain_q = '0;
    else if (se) plain_q = {plain_q[STAGES-2:0], si};
    else plain_q = cd;
    mode_at_edge = m;
    @(negedge clk);
    er = exp_raw(plain_q, mode_at_edge);
    chk(scan_out === plain_q[STAGES-1], {req, " scan_out"}, 32'(scan_out), 32'(plain_q[STAGES-1]));
    chk(raw_state === er, {req, " raw_state"}, 32'(raw_state), 32'(er));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    plain_q = '0;
    mode_at_edge = 1'b0;
    void'($urandom(32'h5eed_0c3a));
    @(negedge clk);
    // R1: reset in test mode then in system mode
    step(1'b1, 1'b0, 1'b0, 1'b0, 3'b111, "R1 reset test");
    chk(raw_state === 3'b000, "R1 raw zero", 32'(raw_state), 32'h0);
    step(1'b1, 1'b1, 1'b1, 1'b1, 3'b111, "R1 reset sys");
    chk(raw_state === 3'b001, "R1 raw sys zero", 32'(raw_state), 32'h1);
    // R2/R3/R6: capture all values in test mode
    for (int v = 0; v < 8; v++) begin
      step(1'b0, 1'b0, 1'b0, 1'b0, 3'(v), "R3 R6 test capture");
      chk(raw_state === 3'(v), "R2 test mode plain", 32'(raw_state), 32'(v));
    end
    // R4/R8: capture all values in system mode
    for (int v = 0; v < 8; v++) begin
      step(1'b0, 1'b1, 1'b0, 1'b0, 3'(v), "R4 R6 sys capture");
      chk(raw_state !== 3'(v), "R8 sys differs", 32'(raw_state), 32'(v));
    end
    // R5: shift a walking pattern in each mode
    for (int m = 0; m < 2; m++)
      for (int i = 0; i < 8; i++)
        step(1'b0, 1'(m), 1'b1, 1'(i == 2 || i == 3), 3'b000, "R5 shift");
    // R7: toggle mode every cycle while shifting
    for (int i = 0; i < 16; i++)
      step(1'b0, 1'(i % 2), 1'b1, 1'((i * 5) % 3 == 0), 3'b000, "R7 toggle shift");
    step(1'b0, 1'b0, 1'b0, 1'b0, 3'b101, "R7 capture before switch");
    step(1'b0, 1'b1, 1'b1, 1'b0, 3'b000, "R7 switch to sys");
    step(1'b0, 1'b0, 1'b1, 1'b1, 3'b000, "R7 switch to test");
    // Mixed random run
    for (int i = 0; i < 600; i++) begin
      logic r;
      r = ($urandom % 50) == 0;
      step(r, 1'($urandom), 1'(($urandom % 4) != 0), 1'($urandom), 3'($urandom),
           r ? "R1 random reset" : "R5 R6 R7 random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule